// File: doc/BRIEF.md
# Per-Line Violation Learning Mode Selector

This block keeps one small record per memory line and uses it to choose which conflict-avoidance mechanism applies to that line. The choices are plain speculation, delay-and-disambiguate, value-predict, stall-and-release and stall-and-wait. The speculation hardware reports events against a line index. A potential violation on a line with no record opens one, placing the line in delay-and-disambiguate or value-predict. Squashes counted under the current mechanism push the line on toward the two stall mechanisms. A "squash avoided" report marks the current mechanism as helping.

Every line also drifts back toward plain speculation. A commit counter starts an aging pass after a programmable number of commit ticks. The pass visits each line in index order, one per cycle, and gives way to any event presented in the same cycle. On each visit a line whose saved-squash mark is set only loses the mark. Any other tracked line drops one step toward plain speculation. A lookup port returns a line's mechanism after a fixed pipeline latency. The records live in a simple-dual-port style memory, with the valid bits held in resettable flops.

Top module: `vls_mode_table`

## Requirements
- R1: After reset every line reads back as plain speculation (mode code 0), and `lk_valid_o` stays low until a lookup has been made.
- R2: A potential violation (`ev_kind_i`=0) or a squash (`ev_kind_i`=1) on a line that reads as plain opens the line. It takes delay-and-disambiguate (code 1) when `ev_pred_i`=0 and value-predict (code 2) when `ev_pred_i`=1.
- R3: Each squash on a line in code 1 or 2 adds one to the line's squash count. The squash that brings the count to `thr_sr_i` moves the line to stall-and-release (code 3). A threshold of 0 behaves like 1.
- R4: Each squash on a line in code 3 adds one to the count, and reaching `thr_sw_i` moves the line to stall-and-wait (code 4). Further squashes in code 4 keep the line there.
- R5: Some events leave every line unchanged: a potential violation on a tracked line (code 1 to 4), an event with `ev_kind_i`=3, and a saved report (`ev_kind_i`=2) on a plain line.
- R6: The commit tick that brings the commit count to `age_period_i` (0 acts as 1) resets the count and starts an aging pass. A tick that hits while a pass is running queues one more pass, which starts as soon as the current one ends. The first visit happens in the cycle after the triggering tick. A pass visits lines 0 to LINES-1 in order, one per cycle, and skips any cycle in which `ev_valid_i` is high.
- R7: An aging visit to a tracked line whose saved mark is set (set by `ev_kind_i`=2) only clears the mark. Without the mark the line steps down: 4 goes to 3, 3 goes to 1, and 1 or 2 go to 0.
- R8: A lookup request in cycle c raises `lk_valid_o` in cycle c+LOOKUP_LAT, with the line's mode as it stands after every event and aging visit from cycles before c.
- R9: Every change of mode clears the line's squash count, so a line that has just escalated needs the full next threshold of squashes to escalate again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid_i | input | 1 | Event present this cycle |
| ev_kind_i | input | 2 | 0 potential violation, 1 squash, 2 squash avoided, 3 no operation |
| ev_line_i | input | $clog2(LINES) | Line index of the event |
| ev_pred_i | input | 1 | Open the line in value-predict rather than delay-and-disambiguate |
| commit_i | input | 1 | Global commit tick |
| thr_sr_i | input | CNT_W | Squashes needed to move to stall-and-release |
| thr_sw_i | input | CNT_W | Squashes needed to move to stall-and-wait |
| age_period_i | input | AGE_W | Commit ticks between aging passes |
| lk_req_i | input | 1 | Lookup request |
| lk_line_i | input | $clog2(LINES) | Line index of the lookup |
| lk_valid_o | output | 1 | Lookup result present |
| lk_mode_o | output | 3 | Mode of the looked-up line |

## Verification
A wrong squash count or a count that is not cleared on escalation shows up as an early or late move into a stall mode. It appears on the first lookup issued after the escalating squash, LOOKUP_LAT cycles later. Lost forwarding between back-to-back updates of one line shows as a missed escalation when squashes arrive in consecutive cycles. A wrong aging pointer or a pass that fails to give way to events shows as lines stepping down in the wrong pass, or not at all. This is visible once the pass ends, plus the lookup latency. Every lookup result is compared against a behavioural model on every clock, so any divergence is caught within one lookup latency of the first lookup that touches the damaged line.

// File: rtl/vls_pkg.sv
package vls_pkg;

  typedef enum logic [2:0] {
    MD_PLAIN      = 3'd0,
    MD_DELAY      = 3'd1,
    MD_VALUE      = 3'd2,
    MD_STALL_REL  = 3'd3,
    MD_STALL_WAIT = 3'd4
  } mode_e;

  typedef enum logic [1:0] {
    EV_POTENTIAL = 2'd0,
    EV_SQUASH    = 2'd1,
    EV_SAVED     = 2'd2,
    EV_NONE      = 2'd3
  } ev_kind_e;

endpackage

// File: rtl/vls_entry_update.sv
// Next-state function for one line record: event or aging visit.
module vls_entry_update
  import vls_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             old_valid,
  input  mode_e            old_mode,
  input  logic [CNT_W-1:0] old_cnt,
  input  logic             old_saved,
  input  logic             is_age,
  input  ev_kind_e         kind,
  input  logic             pred,
  input  logic [CNT_W-1:0] thr_sr,
  input  logic [CNT_W-1:0] thr_sw,
  output logic             new_valid,
  output mode_e            new_mode,
  output logic [CNT_W-1:0] new_cnt,
  output logic             new_saved
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             tracked;
  logic [CNT_W-1:0] cnt_inc;
  mode_e            open_mode;

  assign tracked   = old_valid && (old_mode != MD_PLAIN);
  assign cnt_inc   = (old_cnt == CNT_MAX) ? old_cnt : old_cnt + 1'b1;
  assign open_mode = pred ? MD_VALUE : MD_DELAY;

  always_comb begin
    new_valid = old_valid;
    new_mode  = old_mode;
    new_cnt   = old_cnt;
    new_saved = old_saved;
    if (is_age) begin
      if (tracked) begin
        if (old_saved) begin
          new_saved = 1'b0;
        end else begin
          new_cnt   = '0;
          new_saved = 1'b0;
          case (old_mode)
            MD_STALL_WAIT: new_mode = MD_STALL_REL;
            MD_STALL_REL:  new_mode = MD_DELAY;
            default: begin
              new_mode  = MD_PLAIN;
              new_valid = 1'b0;
            end
          endcase
        end
      end
    end else begin
      case (kind)
        EV_POTENTIAL: begin
          if (!tracked) begin
            new_valid = 1'b1;
            new_mode  = open_mode;
            new_cnt   = '0;
            new_saved = 1'b0;
          end
        end
        EV_SQUASH: begin
          if (!tracked) begin
            new_valid = 1'b1;
            new_mode  = open_mode;
            new_cnt   = '0;
            new_saved = 1'b0;
          end else begin
            case (old_mode)
              MD_DELAY, MD_VALUE: begin
                if (cnt_inc >= thr_sr) begin
                  new_mode  = MD_STALL_REL;
                  new_cnt   = '0;
                  new_saved = 1'b0;
                end else begin
                  new_cnt = cnt_inc;
                end
              end
              MD_STALL_REL: begin
                if (cnt_inc >= thr_sw) begin
                  new_mode  = MD_STALL_WAIT;
                  new_cnt   = '0;
                  new_saved = 1'b0;
                end else begin
                  new_cnt = cnt_inc;
                end
              end
              default: new_cnt = cnt_inc;
            endcase
          end
        end
        EV_SAVED: begin
          if (tracked) new_saved = 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/vls_age_sweep.sv
// Commit counter and aging pass walker; yields to events.
module vls_age_sweep #(
  parameter int LINES = 2048,
  parameter int AGE_W = 16,
  localparam int IW   = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             commit_i,
  input  logic [AGE_W-1:0] age_period_i,
  input  logic             ev_busy_i,
  output logic             issue_o,
  output logic [IW-1:0]    idx_o,
  output logic             act_o
);

  localparam logic [IW-1:0] LAST_IDX = IW'(LINES - 1);

  logic [AGE_W-1:0] ccnt_q;
  logic [AGE_W:0]   ccnt_nxt;
  logic             act_q, pend_q, hit, last;
  logic [IW-1:0]    ptr_q;

  assign ccnt_nxt = {1'b0, ccnt_q} + {{AGE_W{1'b0}}, 1'b1};
  assign hit      = commit_i && (ccnt_nxt >= {1'b0, age_period_i});
  assign issue_o  = act_q && !ev_busy_i;
  assign last     = issue_o && (ptr_q == LAST_IDX);
  assign idx_o    = ptr_q;
  assign act_o    = act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ccnt_q <= '0;
      act_q  <= 1'b0;
      pend_q <= 1'b0;
      ptr_q  <= '0;
    end else begin
      if (commit_i) ccnt_q <= hit ? '0 : ccnt_nxt[AGE_W-1:0];
      if (act_q) begin
        if (issue_o) ptr_q <= last ? '0 : ptr_q + 1'b1;
        if (last) begin
          act_q  <= pend_q | hit;
          pend_q <= 1'b0;
        end else if (hit) begin
          pend_q <= 1'b1;
        end
      end else if (hit) begin
        act_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/vls_lookup_delay.sv
// Fixed-depth delay line bringing lookup results to the specified latency.
module vls_lookup_delay #(
  parameter int STAGES = 19
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_vld,
  input  logic [2:0] in_mode,
  output logic       out_vld,
  output logic [2:0] out_mode
);

  logic       v_q [STAGES];
  logic [2:0] m_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) begin
        v_q[i] <= 1'b0;
        m_q[i] <= 3'd0;
      end
    end else begin
      v_q[0] <= in_vld;
      m_q[0] <= in_mode;
      for (int i = 1; i < STAGES; i++) begin
        v_q[i] <= v_q[i-1];
        m_q[i] <= m_q[i-1];
      end
    end
  end

  assign out_vld  = v_q[STAGES-1];
  assign out_mode = m_q[STAGES-1];

endmodule

// File: rtl/vls_mode_table.sv
// Per-line mechanism table: record memory, update pipeline, aging, lookup.
module vls_mode_table
  import vls_pkg::*;
#(
  parameter int LINES      = 2048,
  parameter int CNT_W      = 4,
  parameter int AGE_W      = 16,
  parameter int LOOKUP_LAT = 20,
  localparam int IW        = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_valid_i,
  input  logic [1:0]       ev_kind_i,
  input  logic [IW-1:0]    ev_line_i,
  input  logic             ev_pred_i,
  input  logic             commit_i,
  input  logic [CNT_W-1:0] thr_sr_i,
  input  logic [CNT_W-1:0] thr_sw_i,
  input  logic [AGE_W-1:0] age_period_i,
  input  logic             lk_req_i,
  input  logic [IW-1:0]    lk_line_i,
  output logic             lk_valid_o,
  output logic [2:0]       lk_mode_o
);

  localparam int DW = CNT_W + 4;  // {saved, cnt, mode}

  // issue stage
  logic          sweep_issue, sweep_act;
  logic [IW-1:0] sweep_ptr;
  logic          op_vld;
  logic [IW-1:0] op_idx;

  vls_age_sweep #(.LINES(LINES), .AGE_W(AGE_W)) u_sweep (
    .clk(clk), .rst(rst), .commit_i(commit_i), .age_period_i(age_period_i),
    .ev_busy_i(ev_valid_i), .issue_o(sweep_issue), .idx_o(sweep_ptr),
    .act_o(sweep_act)
  );

  assign op_vld = ev_valid_i | sweep_issue;
  assign op_idx = ev_valid_i ? ev_line_i : sweep_ptr;

  // record storage
  logic [DW-1:0]    mem_q [LINES];
  logic [LINES-1:0] vld_q;
  logic [DW-1:0]    rd_a_q, rd_b_q;
  logic             va_q, vb_q;

  // update stage registers
  logic          s1_vld, s1_is_age, s1_pred;
  ev_kind_e      s1_kind;
  logic [IW-1:0] s1_idx;
  logic          lk1_vld;
  logic [IW-1:0] lk1_idx;

  // forwarding of the write landing at the same edge as a read
  logic          fw_vld, fw_valid;
  logic [IW-1:0] fw_idx;
  logic [DW-1:0] fw_word;

  logic             new_valid, new_saved;
  mode_e            new_mode;
  logic [CNT_W-1:0] new_cnt;
  logic [DW-1:0]    wr_word;

  assign wr_word = {new_saved, new_cnt, new_mode};

  always_ff @(posedge clk) begin
    if (s1_vld) mem_q[s1_idx] <= wr_word;
    rd_a_q <= mem_q[op_idx];
    rd_b_q <= mem_q[lk_line_i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q     <= '0;
      va_q      <= 1'b0;
      vb_q      <= 1'b0;
      s1_vld    <= 1'b0;
      s1_is_age <= 1'b0;
      s1_pred   <= 1'b0;
      s1_kind   <= EV_NONE;
      s1_idx    <= '0;
      lk1_vld   <= 1'b0;
      lk1_idx   <= '0;
      fw_vld    <= 1'b0;
      fw_valid  <= 1'b0;
      fw_idx    <= '0;
      fw_word   <= '0;
    end else begin
      if (s1_vld) vld_q[s1_idx] <= new_valid;
      va_q      <= vld_q[op_idx];
      vb_q      <= vld_q[lk_line_i];
      s1_vld    <= op_vld;
      s1_is_age <= !ev_valid_i;
      s1_pred   <= ev_pred_i;
      s1_kind   <= ev_kind_e'(ev_kind_i);
      s1_idx    <= op_idx;
      lk1_vld   <= lk_req_i;
      lk1_idx   <= lk_line_i;
      fw_vld    <= s1_vld;
      fw_valid  <= new_valid;
      fw_idx    <= s1_idx;
      fw_word   <= wr_word;
    end
  end

  // resolve current record for the update
  logic             hit_a, cur_a_valid;
  logic [DW-1:0]    cur_a_word;
  logic             old_valid, old_saved;
  mode_e            old_mode;
  logic [CNT_W-1:0] old_cnt;

  assign hit_a       = fw_vld && (fw_idx == s1_idx);
  assign cur_a_valid = hit_a ? fw_valid : va_q;
  assign cur_a_word  = hit_a ? fw_word : rd_a_q;
  assign old_valid   = cur_a_valid;
  assign old_mode    = cur_a_valid ? mode_e'(cur_a_word[2:0]) : MD_PLAIN;
  assign old_cnt     = cur_a_valid ? cur_a_word[CNT_W+2:3] : '0;
  assign old_saved   = cur_a_valid && cur_a_word[DW-1];

  vls_entry_update #(.CNT_W(CNT_W)) u_update (
    .old_valid(old_valid), .old_mode(old_mode), .old_cnt(old_cnt),
    .old_saved(old_saved), .is_age(s1_is_age), .kind(s1_kind),
    .pred(s1_pred), .thr_sr(thr_sr_i), .thr_sw(thr_sw_i),
    .new_valid(new_valid), .new_mode(new_mode), .new_cnt(new_cnt),
    .new_saved(new_saved)
  );

  // resolve lookup result
  logic       hit_b, cur_b_valid;
  logic [2:0] cur_b_mode, lk_mode_rd;

  assign hit_b       = fw_vld && (fw_idx == lk1_idx);
  assign cur_b_valid = hit_b ? fw_valid : vb_q;
  assign cur_b_mode  = hit_b ? fw_word[2:0] : rd_b_q[2:0];
  assign lk_mode_rd  = cur_b_valid ? cur_b_mode : 3'd0;

  vls_lookup_delay #(.STAGES(LOOKUP_LAT - 1)) u_delay (
    .clk(clk), .rst(rst), .in_vld(lk1_vld), .in_mode(lk_mode_rd),
    .out_vld(lk_valid_o), .out_mode(lk_mode_o)
  );

endmodule

// File: rtl/vls_mode_table_chk.sv
module vls_mode_table_chk #(
  parameter int LINES = 2048,
  parameter int CNT_W = 4,
  localparam int IW   = $clog2(LINES)
) (
  input logic             clk,
  input logic             rst,
  input logic             ev_valid_i,
  input logic             lk_valid_o,
  input logic [2:0]       lk_mode_o,
  input logic             sweep_act,
  input logic [IW-1:0]    sweep_ptr,
  input logic             s1_vld,
  input logic             s1_is_age,
  input logic [1:0]       s1_kind,
  input logic [2:0]       old_mode,
  input logic [2:0]       new_mode,
  input logic [CNT_W-1:0] new_cnt
);

  localparam logic [IW-1:0] LAST_IDX = IW'(LINES - 1);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !lk_valid_o); // R1

  AST_SQUASH_NO_DEMOTE: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && !s1_is_age && s1_kind == 2'd1) |-> (new_mode >= old_mode)); // R3

  AST_IGNORED_KIND: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && !s1_is_age && s1_kind == 2'd3) |-> (new_mode == old_mode)); // R5

  AST_SWEEP_YIELD: assert property (@(posedge clk) disable iff (rst)
    (sweep_act && ev_valid_i) |=> $stable(sweep_ptr)); // R6

  AST_SWEEP_STEP: assert property (@(posedge clk) disable iff (rst)
    (sweep_act && !ev_valid_i && sweep_ptr != LAST_IDX)
      |=> (sweep_ptr == IW'($past(sweep_ptr) + 1'b1))); // R6

  AST_AGE_NO_PROMOTE: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && s1_is_age) |-> (new_mode <= old_mode)); // R7

  AST_LK_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    lk_valid_o |-> (lk_mode_o <= 3'd4)); // R8

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && new_mode != old_mode) |-> (new_cnt == '0)); // R9

endmodule

bind vls_mode_table vls_mode_table_chk #(.LINES(LINES), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .ev_valid_i(ev_valid_i), .lk_valid_o(lk_valid_o),
  .lk_mode_o(lk_mode_o), .sweep_act(sweep_act), .sweep_ptr(sweep_ptr),
  .s1_vld(s1_vld), .s1_is_age(s1_is_age), .s1_kind(s1_kind),
  .old_mode(old_mode), .new_mode(new_mode), .new_cnt(new_cnt)
);

// File: tb/sim_vls_mode_table.sv
`timescale 1ns/1ps
module sim_vls_mode_table;

  localparam int LINES = 16;
  localparam int CNT_W = 4;
  localparam int AGE_W = 8;
  localparam int LAT   = 20;
  localparam int IW    = $clog2(LINES);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             ev_valid_i = 1'b0;
  logic [1:0]       ev_kind_i = 2'd0;
  logic [IW-1:0]    ev_line_i = '0;
  logic             ev_pred_i = 1'b0;
  logic             commit_i = 1'b0;
  logic [CNT_W-1:0] thr_sr_i = 4'd3;
  logic [CNT_W-1:0] thr_sw_i = 4'd2;
  logic [AGE_W-1:0] age_period_i = 8'd200;
  logic             lk_req_i = 1'b0;
  logic [IW-1:0]    lk_line_i = '0;
  logic             lk_valid_o;
  logic [2:0]       lk_mode_o;

  vls_mode_table #(.LINES(LINES), .CNT_W(CNT_W), .AGE_W(AGE_W),
                   .LOOKUP_LAT(LAT)) u0 (.*);

  always #2.5 clk = ~clk;

  int    total = 0, fails = 0, cyc = 0;
  string phase = "R1";
  bit    done = 1'b0;

  task automatic chk(bit ok, string what, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", phase, what, act, exp);
    end
  endtask

  // behavioural reference
  int m_mode [LINES];
  int m_cnt  [LINES];
  bit m_sav  [LINES];
  int due_q[$];
  int exp_q[$];
  bit sw_act, sw_pend;
  int sw_ptr, ccnt;
  int cmax = (1 << CNT_W) - 1;

  function automatic void apply_ev(int k, int l, bit p);
    int nc;
    nc = (m_cnt[l] == cmax) ? m_cnt[l] : m_cnt[l] + 1;
    if ((k == 0 || k == 1) && m_mode[l] == 0) begin
      m_mode[l] = p ? 2 : 1; m_cnt[l] = 0; m_sav[l] = 0;
    end else if (k == 1) begin
      if ((m_mode[l] == 1 || m_mode[l] == 2) && nc >= int'(thr_sr_i)) begin
        m_mode[l] = 3; m_cnt[l] = 0; m_sav[l] = 0;
      end else if (m_mode[l] == 3 && nc >= int'(thr_sw_i)) begin
        m_mode[l] = 4; m_cnt[l] = 0; m_sav[l] = 0;
      end else m_cnt[l] = nc;
    end else if (k == 2 && m_mode[l] != 0) m_sav[l] = 1;
  endfunction

  function automatic void apply_age(int l);
    if (m_mode[l] != 0) begin
      if (m_sav[l]) m_sav[l] = 0;
      else begin
        m_mode[l] = (m_mode[l] == 4) ? 3 : (m_mode[l] == 3) ? 1 : 0;
        m_cnt[l] = 0;
      end
    end
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) begin
        m_mode[i] = 0; m_cnt[i] = 0; m_sav[i] = 0;
      end
      due_q.delete(); exp_q.delete();
      sw_act = 0; sw_pend = 0; sw_ptr = 0; ccnt = 0;
    end else begin
      bit hit, issue, last;
      if (lk_req_i) begin
        due_q.push_back(cyc + LAT);
        exp_q.push_back(m_mode[lk_line_i]);
      end
      issue = sw_act && !ev_valid_i;
      last  = issue && (sw_ptr == LINES - 1);
      if (ev_valid_i) apply_ev(ev_kind_i, ev_line_i, ev_pred_i);
      else if (issue) apply_age(sw_ptr);
      hit = commit_i && (ccnt + 1 >= int'(age_period_i));
      if (commit_i) ccnt = hit ? 0 : ccnt + 1;
      if (sw_act) begin
        if (issue) sw_ptr = last ? 0 : sw_ptr + 1;
        if (last) begin sw_act = sw_pend | hit; sw_pend = 0; end
        else if (hit) sw_pend = 1;
      end else if (hit) sw_act = 1;
    end
    cyc++;
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      bit ev;
      ev = (due_q.size() > 0) && (due_q[0] == cyc);
      chk(lk_valid_o == ev, "R8 lk_valid_o timing", lk_valid_o, ev);
      if (ev) begin
        chk(lk_mode_o == 3'(exp_q[0]), "lk_mode_o", lk_mode_o, exp_q[0]);
        void'(due_q.pop_front());
        void'(exp_q.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      fails++; total++;
      $display("FAIL watchdog (R8): ran %0d cycles expected under %0d", cyc, 20000);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  // one cycle of stimulus, driven at a falling edge
  task automatic step(bit ev, int k, int l, bit p, bit lk, int ll, bit cm);
    ev_valid_i = ev; ev_kind_i = 2'(k); ev_line_i = IW'(l); ev_pred_i = p;
    lk_req_i = lk; lk_line_i = IW'(ll); commit_i = cm;
    @(negedge clk);
    ev_valid_i = 0; lk_req_i = 0; commit_i = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic look_all();
    for (int i = 0; i < LINES; i++) step(0, 0, 0, 0, 1, i, 0);
    idle(LAT + 2);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    phase = "R1";
    chk(lk_valid_o == 1'b0, "lk_valid_o after reset", lk_valid_o, 0);
    chk(lk_mode_o == 3'd0, "lk_mode_o after reset", lk_mode_o, 0);
    step(0, 0, 0, 0, 1, 0, 0); step(0, 0, 0, 0, 1, 5, 0); step(0, 0, 0, 0, 1, 15, 0);
    idle(LAT + 2);

    phase = "R2 open";
    step(1, 0, 1, 0, 0, 0, 0);
    step(1, 0, 2, 1, 1, 1, 0);
    step(1, 1, 3, 0, 1, 2, 0);
    step(0, 0, 0, 0, 1, 3, 0);
    idle(LAT + 2);

    phase = "R3 escalate";
    step(1, 1, 1, 0, 1, 1, 0);
    step(1, 1, 1, 0, 1, 1, 0);
    step(1, 1, 1, 0, 1, 1, 0);
    step(0, 0, 0, 0, 1, 1, 0);
    idle(2); thr_sr_i = 4'd0;
    step(1, 1, 2, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 2, 0);
    idle(2); thr_sr_i = 4'd2;
    idle(LAT + 2);

    phase = "R9 count cleared";
    step(1, 1, 3, 0, 0, 0, 0);
    step(1, 1, 3, 0, 1, 3, 0);
    step(1, 1, 3, 0, 1, 3, 0);
    step(0, 0, 0, 0, 1, 3, 0);
    idle(LAT + 2);

    phase = "R4 stall-wait";
    step(1, 1, 1, 0, 1, 1, 0);
    step(1, 1, 1, 0, 1, 1, 0);
    step(0, 0, 0, 0, 1, 1, 0);
    for (int i = 0; i < 20; i++) step(1, 1, 1, 0, 1, 1, 0);
    idle(LAT + 2);

    phase = "R5 ignored";
    step(1, 0, 1, 1, 0, 0, 0);
    step(1, 3, 4, 0, 0, 0, 0);
    step(1, 2, 5, 0, 0, 0, 0);
    step(1, 3, 2, 0, 1, 1, 0);
    step(0, 0, 0, 0, 1, 4, 0);
    step(0, 0, 0, 0, 1, 5, 0);
    step(0, 0, 0, 0, 1, 2, 0);
    idle(LAT + 2);

    phase = "R6 R7 aging pass";
    age_period_i = 8'd3;
    step(1, 2, 1, 0, 0, 0, 0);
    step(1, 0, 6, 1, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 1, i, 0);
    step(1, 1, 6, 0, 1, 6, 0);
    step(1, 1, 7, 1, 1, 7, 0);
    step(0, 0, 0, 0, 1, 2, 0);
    idle(20);
    look_all();
    step(0, 0, 0, 0, 0, 0, 1); step(0, 0, 0, 0, 0, 0, 1); step(0, 0, 0, 0, 0, 0, 1);
    idle(20);
    look_all();

    phase = "R6 queued pass";
    age_period_i = 8'd1;
    step(1, 1, 8, 0, 0, 0, 0);
    step(1, 1, 9, 0, 0, 0, 0);
    step(1, 1, 9, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1, 9, 1);
    step(0, 0, 0, 0, 1, 8, 1);
    idle(6);
    step(1, 2, 9, 0, 1, 9, 0);
    idle(40);
    look_all();

    phase = "R8 burst";
    age_period_i = 8'd200;
    step(1, 0, 10, 0, 1, 10, 0);
    step(1, 1, 10, 0, 1, 10, 0);
    step(1, 1, 10, 0, 1, 10, 0);
    look_all();

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule